// File: doc/BRIEF.md
# Acquisition and Power-Down Sequencer

This block sits between the serial-interface decoder and the analog front end of an eight-input data-acquisition channel. It turns decoded bus events into the phases of a sample. These phases are tracking (track/hold open), converting (held sample handed to the successive-approximation core), and idle. It also keeps the power state of the front end. The serial decoder supplies single-cycle strobes:
- one when the channel, range and polarity fields of a control byte are complete;
- one when the two power-mode bits are complete;
- one for a bus STOP;
- one when an address-matched write has been followed by one more received bit (the wake point).

The converter core reports the end of each conversion. An active-low shutdown pin overrides everything.

The settings taken from the control byte are held in registers that feed the multiplexer and the gain stage. The power mode requested by a control byte is only recorded at first. It is applied at the edge where that conversion finishes. This makes it possible to ask for standby on every sample and get an automatic low-power state after each result, while the reference buffer stays up so that the next sample needs no warm-up. Power is reported as status outputs only.

Top module: `acqseq_top`

## Requirements
- R1: After reset the block is idle: `track_o`, `converting_o` and `conv_start_o` are low, `chan_o`, `range_o` and `bipolar_o` are zero, `pwr_mode_o` is 2'b00 (normal), and `refbuf_on_o`, `core_on_o` and `bandgap_on_o` are high.
- R2: In normal mode, while idle or tracking, a `field_stb_i` pulse with shutdown released makes `track_o` high and loads `chan_o`, `range_o` and `bipolar_o` from the field inputs at the same edge.
- R3: A `stop_i` pulse while tracking ends tracking, raises `converting_o` and gives a `conv_start_o` pulse one cycle wide, all at the same edge. If the same cycle also carries a field strobe, the strobe is ignored. A `stop_i` pulse while idle or converting has no effect.
- R4: While converting, field strobes change neither the held settings nor the phase. `conv_done_i` while converting returns the block to idle at that edge.
- R5: Power bits are decoded as 2'b0x = normal (output code 2'b00), 2'b10 = standby (2'b10) and 2'b11 = full power-down (2'b11). They are recorded only when `pwr_stb_i` arrives while tracking. `pwr_mode_o` keeps its value until the edge where `conv_done_i` ends that conversion, and then takes the recorded mode.
- R6: In standby `refbuf_on_o` is high and `core_on_o` is low. In full power-down both are low. `bandgap_on_o` is high in every mode.
- R7: In standby or software full power-down, field strobes are ignored: `track_o` stays low and the held settings are unchanged. `wake_i` returns the block to normal mode at the next edge and clears the recorded mode to normal. `wake_i` in normal mode has no effect.
- R8: A low `shdn_n_i` sampled at an edge forces full power-down and aborts tracking or conversion at that edge. While it stays low, strobes, STOP, wake and done are all ignored. The first edge that samples it high again restores normal mode.
- R9: `conv_done_i` outside a conversion has no effect.
- R10: A field strobe in the cycle right after a wake starts tracking at once. A standby-per-sample sequence therefore needs no start-up cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_stb_i | input | 1 | Channel/range/polarity fields of a control byte complete |
| field_chan_i | input | 3 | Channel number from the control byte |
| field_range_i | input | 1 | Full-scale range select (1 = wide) |
| field_bipolar_i | input | 1 | Polarity select (1 = bipolar) |
| pwr_stb_i | input | 1 | Power-mode bits of the control byte complete |
| pwr_bits_i | input | 2 | Requested power-mode bits |
| stop_i | input | 1 | Bus STOP detected |
| wake_i | input | 1 | Address-matched write plus one bit received |
| shdn_n_i | input | 1 | Hardware shutdown, active low |
| conv_done_i | input | 1 | Converter core finished the current sample |
| track_o | output | 1 | Track/hold in tracking |
| conv_start_o | output | 1 | One-cycle start pulse to the converter core |
| converting_o | output | 1 | Conversion in progress (sample held) |
| chan_o | output | 3 | Held channel number |
| range_o | output | 1 | Held range select |
| bipolar_o | output | 1 | Held polarity select |
| pwr_mode_o | output | 2 | Power mode: 00 normal, 10 standby, 11 full |
| refbuf_on_o | output | 1 | Reference buffer enabled |
| core_on_o | output | 1 | Converter and input stage enabled |
| bandgap_on_o | output | 1 | Bandgap enabled |

## Verification
Every event has a single-edge response. A strobe, STOP, done, wake or shutdown level present before a rising edge shows on the outputs just after that edge. The one exception is `conv_start_o`, which is high for exactly that one cycle. The bench drives each stimulus on a falling edge and lets a reference model queue the expected output word after the next rising edge. A separate monitor compares that word at the following falling edge, so every comparison falls exactly one edge after its stimulus. The deferred power change is checked on both sides of the done edge: unchanged in the cycles before it and changed in the cycle after.

// File: rtl/acqseq_pkg.sv
package acqseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_STBY   = 2'b10,
    PM_FULL   = 2'b11
  } pmode_e;

  // Two request bits to a power mode: upper bit clear means normal.
  function automatic pmode_e pd_decode(input logic [1:0] bits);
    if (!bits[1])     return PM_NORMAL;
    else if (bits[0]) return PM_FULL;
    else              return PM_STBY;
  endfunction

  // Reference buffer is kept up in every mode but full power-down.
  function automatic logic refbuf_active(input pmode_e m);
    return (m != PM_FULL);
  endfunction

  // Converter core and input stage only run in normal mode.
  function automatic logic core_active(input pmode_e m);
    return (m == PM_NORMAL);
  endfunction

endpackage

// File: rtl/acqseq_cfg_hold.sv
module acqseq_cfg_hold #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] chan_in,
  input  logic            range_in,
  input  logic            bip_in,
  output logic [CH_W-1:0] chan_q,
  output logic            range_q,
  output logic            bip_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      range_q <= 1'b0;
      bip_q   <= 1'b0;
    end else if (load) begin
      chan_q  <= chan_in;
      range_q <= range_in;
      bip_q   <= bip_in;
    end
  end

endmodule

// File: rtl/acqseq_phase_fsm.sv
module acqseq_phase_fsm
  import acqseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shdn_n,
  input  logic   field_stb,
  input  logic   stop,
  input  logic   done,
  input  logic   pwr_normal,
  output phase_e phase_q,
  output logic   conv_start_q,
  output logic   cfg_load,
  output logic   conv_fire,
  output logic   conv_end
);

  phase_e phase_d;

  // Settings load from idle (normal mode only) or re-load while tracking,
  // unless the same cycle carries the STOP that freezes them.
  assign cfg_load  = shdn_n && field_stb &&
                     (((phase_q == PH_IDLE) && pwr_normal) ||
                      ((phase_q == PH_ACQ) && !stop));
  assign conv_fire = shdn_n && stop && (phase_q == PH_ACQ);
  assign conv_end  = shdn_n && done && (phase_q == PH_CONV);

  always_comb begin
    phase_d = phase_q;
    if (!shdn_n)        phase_d = PH_IDLE;
    else if (conv_fire) phase_d = PH_CONV;
    else if (cfg_load)  phase_d = PH_ACQ;
    else if (conv_end)  phase_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      conv_start_q <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      conv_start_q <= conv_fire;
    end
  end

endmodule

// File: rtl/acqseq_power_ctrl.sv
module acqseq_power_ctrl
  import acqseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       wake,
  input  logic       pwr_stb,
  input  logic [1:0] pwr_bits,
  input  logic       in_acq,
  input  logic       conv_end,
  output pmode_e     mode_q,
  output pmode_e     pend_q,
  output logic       hw_hold_q,
  output logic       wake_accept,
  output logic       pend_capture
);

  assign wake_accept  = shdn_n && !hw_hold_q && wake && (mode_q != PM_NORMAL);
  assign pend_capture = shdn_n && !hw_hold_q && !wake_accept && pwr_stb && in_acq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= PM_NORMAL;
      pend_q    <= PM_NORMAL;
      hw_hold_q <= 1'b0;
    end else if (!shdn_n) begin
      mode_q    <= PM_FULL;
      pend_q    <= PM_NORMAL;
      hw_hold_q <= 1'b1;
    end else if (hw_hold_q) begin
      mode_q    <= PM_NORMAL;
      hw_hold_q <= 1'b0;
    end else if (wake_accept) begin
      mode_q <= PM_NORMAL;
      pend_q <= PM_NORMAL;
    end else begin
      if (pend_capture) pend_q <= pd_decode(pwr_bits);
      if (conv_end)     mode_q <= pend_q;
    end
  end

endmodule

// File: rtl/acqseq_top.sv
module acqseq_top
  import acqseq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      field_stb_i,
  input  logic [$clog2(NUM_CH)-1:0] field_chan_i,
  input  logic                      field_range_i,
  input  logic                      field_bipolar_i,
  input  logic                      pwr_stb_i,
  input  logic [1:0]                pwr_bits_i,
  input  logic                      stop_i,
  input  logic                      wake_i,
  input  logic                      shdn_n_i,
  input  logic                      conv_done_i,
  output logic                      track_o,
  output logic                      conv_start_o,
  output logic                      converting_o,
  output logic [$clog2(NUM_CH)-1:0] chan_o,
  output logic                      range_o,
  output logic                      bipolar_o,
  output logic [1:0]                pwr_mode_o,
  output logic                      refbuf_on_o,
  output logic                      core_on_o,
  output logic                      bandgap_on_o
);

  localparam int CH_W = $clog2(NUM_CH);

  phase_e phase;
  pmode_e mode;
  pmode_e pend_mode;
  logic   hw_hold;
  logic   cfg_load;
  logic   conv_fire;
  logic   conv_end;
  logic   wake_accept;
  logic   pend_capture;
  logic   start_q;

  acqseq_phase_fsm u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .shdn_n       (shdn_n_i),
    .field_stb    (field_stb_i),
    .stop         (stop_i),
    .done         (conv_done_i),
    .pwr_normal   (mode == PM_NORMAL),
    .phase_q      (phase),
    .conv_start_q (start_q),
    .cfg_load     (cfg_load),
    .conv_fire    (conv_fire),
    .conv_end     (conv_end)
  );

  acqseq_cfg_hold #(.CH_W(CH_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .chan_in  (field_chan_i),
    .range_in (field_range_i),
    .bip_in   (field_bipolar_i),
    .chan_q   (chan_o),
    .range_q  (range_o),
    .bip_q    (bipolar_o)
  );

  acqseq_power_ctrl u_power (
    .clk          (clk),
    .rst_n        (rst_n),
    .shdn_n       (shdn_n_i),
    .wake         (wake_i),
    .pwr_stb      (pwr_stb_i),
    .pwr_bits     (pwr_bits_i),
    .in_acq       (phase == PH_ACQ),
    .conv_end     (conv_end),
    .mode_q       (mode),
    .pend_q       (pend_mode),
    .hw_hold_q    (hw_hold),
    .wake_accept  (wake_accept),
    .pend_capture (pend_capture)
  );

  assign track_o      = (phase == PH_ACQ);
  assign converting_o = (phase == PH_CONV);
  assign conv_start_o = start_q;
  assign pwr_mode_o   = mode;
  assign refbuf_on_o  = refbuf_active(mode);
  assign core_on_o    = core_active(mode);
  assign bandgap_on_o = 1'b1;

endmodule

// File: rtl/acqseq_checks.sv
module acqseq_checks #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            shdn_n_i,
  input logic            field_stb_i,
  input logic            stop_i,
  input logic            conv_done_i,
  input logic            track_o,
  input logic            converting_o,
  input logic            conv_start_o,
  input logic [CH_W-1:0] chan_o,
  input logic            range_o,
  input logic            bipolar_o,
  input logic [1:0]      pwr_mode_o,
  input logic            cfg_load,
  input logic            conv_end
);

  a_r2_strobe_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n_i && field_stb_i && !track_o && !converting_o && pwr_mode_o == 2'b00)
      |=> track_o);

  a_r3_stop_converts: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n_i && track_o && stop_i) |=> (converting_o && conv_start_o));

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    converting_o |=> $stable({chan_o, range_o, bipolar_o}));

  a_r4_no_load_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    converting_o |-> !cfg_load);

  a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(track_o && converting_o));

  a_r5_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (converting_o && !conv_done_i && shdn_n_i) |=> $stable(pwr_mode_o));

  a_r5_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> (!converting_o && !track_o));

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode_o != 2'b00) |-> (!track_o && !converting_o));

  a_r8_shdn_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |=> (pwr_mode_o == 2'b11 && !track_o && !converting_o && !conv_start_o));

endmodule

bind acqseq_top acqseq_checks #(.CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shdn_n_i     (shdn_n_i),
  .field_stb_i  (field_stb_i),
  .stop_i       (stop_i),
  .conv_done_i  (conv_done_i),
  .track_o      (track_o),
  .converting_o (converting_o),
  .conv_start_o (conv_start_o),
  .chan_o       (chan_o),
  .range_o      (range_o),
  .bipolar_o    (bipolar_o),
  .pwr_mode_o   (pwr_mode_o),
  .cfg_load     (cfg_load),
  .conv_end     (conv_end)
);

// File: tb/tb_acqseq_top.sv
module tb_acqseq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       field_stb_i = 1'b0;
  logic [2:0] field_chan_i = '0;
  logic       field_range_i = 1'b0;
  logic       field_bipolar_i = 1'b0;
  logic       pwr_stb_i = 1'b0;
  logic [1:0] pwr_bits_i = '0;
  logic       stop_i = 1'b0;
  logic       wake_i = 1'b0;
  logic       shdn_n_i = 1'b1;
  logic       conv_done_i = 1'b0;
  logic       track_o, conv_start_o, converting_o, range_o, bipolar_o;
  logic [2:0] chan_o;
  logic [1:0] pwr_mode_o;
  logic       refbuf_on_o, core_on_o, bandgap_on_o;

  always #2 clk = ~clk;  // 250 MHz

  acqseq_top dut (
    .clk(clk), .rst_n(rst_n),
    .field_stb_i(field_stb_i), .field_chan_i(field_chan_i),
    .field_range_i(field_range_i), .field_bipolar_i(field_bipolar_i),
    .pwr_stb_i(pwr_stb_i), .pwr_bits_i(pwr_bits_i),
    .stop_i(stop_i), .wake_i(wake_i), .shdn_n_i(shdn_n_i),
    .conv_done_i(conv_done_i),
    .track_o(track_o), .conv_start_o(conv_start_o), .converting_o(converting_o),
    .chan_o(chan_o), .range_o(range_o), .bipolar_o(bipolar_o),
    .pwr_mode_o(pwr_mode_o), .refbuf_on_o(refbuf_on_o), .core_on_o(core_on_o),
    .bandgap_on_o(bandgap_on_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  string       q_tag[$];
  logic [12:0] q_exp[$];

  // Reference model, written from the requirements.
  int         m_ph;     // 0 idle, 1 tracking, 2 converting
  logic       m_start;
  logic [2:0] m_ch;
  logic       m_rg, m_bp, m_hw;
  logic [1:0] m_mode, m_pend;

  function automatic logic [1:0] want_mode(input logic [1:0] b);
    if (b[1] == 1'b0) return 2'b00;
    return b[0] ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [12:0] model_word();
    return {m_ph == 1, m_start, m_ph == 2, m_ch, m_rg, m_bp, m_mode,
            m_mode != 2'b11, m_mode == 2'b00, 1'b1};
  endfunction

  function automatic logic [12:0] dut_word();
    return {track_o, conv_start_o, converting_o, chan_o, range_o, bipolar_o,
            pwr_mode_o, refbuf_on_o, core_on_o, bandgap_on_o};
  endfunction

  // Driver: apply one cycle of stimulus, advance the model, queue the result.
  task automatic step(input string tag, input logic fs, input logic [2:0] ch,
                      input logic rg, input logic bp, input logic ps,
                      input logic [1:0] pb, input logic sp, input logic dn,
                      input logic wk, input logic sd);
    int   old_ph;
    logic [1:0] old_mode;
    logic ended;
    @(negedge clk);
    field_stb_i = fs; field_chan_i = ch; field_range_i = rg; field_bipolar_i = bp;
    pwr_stb_i = ps; pwr_bits_i = pb; stop_i = sp; conv_done_i = dn;
    wake_i = wk; shdn_n_i = sd;
    old_ph = m_ph; old_mode = m_mode; ended = 1'b0; m_start = 1'b0;
    if (!sd) begin
      m_ph = 0; m_mode = 2'b11; m_pend = 2'b00; m_hw = 1'b1;
    end else begin
      if (old_ph == 1 && sp) begin
        m_ph = 2; m_start = 1'b1;
      end else if (fs && ((old_ph == 0 && old_mode == 2'b00) || old_ph == 1)) begin
        m_ph = 1; m_ch = ch; m_rg = rg; m_bp = bp;
      end else if (old_ph == 2 && dn) begin
        m_ph = 0; ended = 1'b1;
      end
      if (m_hw) begin
        m_mode = 2'b00; m_hw = 1'b0;
      end else if (wk && old_mode != 2'b00) begin
        m_mode = 2'b00; m_pend = 2'b00;
      end else begin
        if (ps && old_ph == 1) m_pend = want_mode(pb);
        if (ended) m_mode = m_pend;
      end
    end
    @(posedge clk);
    q_tag.push_back(tag);
    q_exp.push_back(model_word());
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 3'd0, 0, 0, 0, 2'b00, 0, 0, 0, 1);
  endtask
  task automatic strobe(input string tag, input logic [2:0] ch, input logic rg, input logic bp);
    step(tag, 1, ch, rg, bp, 0, 2'b00, 0, 0, 0, 1);
  endtask
  task automatic pset(input string tag, input logic [1:0] pb);
    step(tag, 0, 3'd0, 0, 0, 1, pb, 0, 0, 0, 1);
  endtask
  task automatic stopc(input string tag);
    step(tag, 0, 3'd0, 0, 0, 0, 2'b00, 1, 0, 0, 1);
  endtask
  task automatic donec(input string tag);
    step(tag, 0, 3'd0, 0, 0, 0, 2'b00, 0, 1, 0, 1);
  endtask
  task automatic wakec(input string tag);
    step(tag, 0, 3'd0, 0, 0, 0, 2'b00, 0, 0, 1, 1);
  endtask

  // Monitor: compare queued expectations one falling edge after they are due.
  initial begin
    forever begin
      @(negedge clk);
      while (q_exp.size() > 0) begin
        string       t;
        logic [12:0] e;
        logic [12:0] a;
        t = q_tag.pop_front();
        e = q_exp.pop_front();
        a = dut_word();
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: outputs got %b expected %b", t, a, e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 50000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_ph = 0; m_start = 0; m_ch = '0; m_rg = 0; m_bp = 0;
    m_mode = 2'b00; m_pend = 2'b00; m_hw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle("R1"); idle("R1");
    // R2/R3/R4/R9: a normal-mode sample
    strobe("R2", 3'd5, 1, 0);
    idle("R2");
    pset("R5", 2'b00);
    stopc("R3");
    idle("R3"); idle("R3");
    strobe("R4", 3'd2, 0, 1);
    donec("R4");
    donec("R9");
    stopc("R3");
    // R5/R6: standby applied only at the done edge
    strobe("R2", 3'd3, 0, 1);
    pset("R5", 2'b10);
    idle("R5");
    stopc("R5");
    idle("R5");
    donec("R6");
    strobe("R7", 3'd6, 1, 1);
    wakec("R7");
    strobe("R10", 3'd1, 1, 0);
    pset("R5", 2'b11);
    stopc("R5");
    donec("R6");
    strobe("R7", 3'd4, 0, 0);
    wakec("R7");
    idle("R7");
    // R5: power bits outside tracking are ignored
    pset("R5", 2'b10);
    strobe("R2", 3'd2, 1, 1);
    stopc("R3");
    donec("R5");
    idle("R5");
    // R8: shutdown aborts and blocks everything
    strobe("R2", 3'd7, 0, 1);
    pset("R8", 2'b10);
    stopc("R3");
    step("R8", 0, 3'd0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    step("R8", 1, 3'd5, 1, 1, 0, 2'b00, 1, 0, 0, 0);
    step("R8", 0, 3'd0, 0, 0, 0, 2'b00, 0, 1, 1, 0);
    idle("R8");
    idle("R8");
    strobe("R2", 3'd1, 1, 1);
    step("R8", 0, 3'd0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    idle("R8");
    // R7: wake in normal mode has no effect
    wakec("R7");
    // R3: re-strobe while tracking, then STOP beats a same-cycle strobe
    strobe("R2", 3'd4, 0, 1);
    strobe("R2", 3'd6, 1, 0);
    step("R3", 1, 3'd0, 1, 1, 0, 2'b00, 1, 0, 0, 1);
    idle("R4");
    donec("R4");
    // R5: 2'b01 decodes as normal
    strobe("R2", 3'd3, 1, 1);
    pset("R5", 2'b01);
    stopc("R3");
    donec("R5");
    // R10: standby on every sample, wake then start at once
    strobe("R2", 3'd0, 0, 0);
    pset("R5", 2'b10);
    stopc("R3");
    donec("R10");
    wakec("R10");
    strobe("R10", 3'd7, 1, 1);
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule